// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Flag

This block is a first-in first-out store of 9-bit words, so a byte can carry a parity or control bit along with it. Storage is addressed by circular write and read pointers held inside the block, and the user supplies no address. A write enable stores one word and a read enable delivers the oldest word on a registered output. Both may be given in the same clock. Active-low status outputs report empty, full and more-than-half-full.

An active-low retransmit input rewinds the read pointer to the first location written after reset. Everything written since reset can then be read a second time. On retransmit the word count is rebuilt from the write pointer, and the flags follow it. Retransmit is meaningful only while fewer than `DEPTH` words have been written since reset. An asynchronous active-low reset, released on the clock, clears both pointers and the output register.

Top module: `replay_fifo`

## Requirements
- R1: After reset, `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `rd_data` is 0.
- R2: Words are delivered in the order they were written. When `rd_en` is accepted at a clock edge, `rd_data` shows the oldest stored word from that edge until the next accepted read.
- R3: `empty_n` is 0 exactly when no word is stored. `full_n` is 0 exactly when `DEPTH` words are stored. Both flags follow the count one edge after the operation that changes it.
- R4: A write while `full_n` is 0 stores nothing. The stored contents, read out afterwards, are unchanged.
- R5: A read while `empty_n` is 0 is ignored: `rd_data` keeps its value and `empty_n` stays 0.
- R6: `half_n` is 0 when more than `DEPTH/2` words are stored. It is 1 when `DEPTH/2` or fewer words are stored.
- R7: When `rt_n` is 0 at a clock edge, the next accepted read returns the first word written since reset. The count and all flags become those for the number of words written since reset.
- R8: A read and a write in the same cycle both take effect when the buffer is neither empty nor full, and the count stays the same. When the buffer is full, only the read is taken. When it is empty, only the write is taken.
- R9: Pointers wrap at `DEPTH`, so order is kept across any number of fill and drain passes.
- R10: In a retransmit cycle, a read request is ignored and `rd_data` holds its value. A write request in that cycle is still stored, and it counts as written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Active-low retransmit |
| rd_data | output | 9 | Registered read word |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
Two things can land in one cycle: a read and a write, and a retransmit with a read or write. The bench drives both enables together on a partly filled buffer, on a full one and on an empty one. It also raises `rd_en` and `wr_en` during the retransmit cycle itself. Each edge is judged against a queue model. The model holds a history of everything written since reset, and it predicts the count, the three flags and the output word after every edge.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  parameter int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem
  import replay_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic          rd_ok,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  word_t store_q [DEPTH];
  word_t out_d;

  always_ff @(posedge clk) begin
    if (wr_ok) store_q[wr_addr] <= wr_data;
  end

  always_comb begin
    out_d = rd_data;
    if (rd_ok) out_d = store_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= out_d;
  end
endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rt_n,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic          is_empty, is_full;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CW'(DEPTH));
  assign wr_ok    = wr_en && !is_full;
  assign rd_ok    = rd_en && !is_empty && rt_n;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    cnt_d    = cnt_q;
    if (wr_ok) wr_ptr_d = wr_ptr + AW'(1);
    if (!rt_n) begin
      rd_ptr_d = '0;
      cnt_d    = {1'b0, wr_ptr} + CW'(wr_ok);
    end else begin
      if (rd_ok) rd_ptr_d = rd_ptr + AW'(1);
      cnt_d = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign empty_n = !is_empty;
  assign full_n  = !is_full;
  assign half_n  = !(cnt_q > CW'(HALF));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_ptr)); // R4
  AST_RT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rd_ptr == '0)); // R7
  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_n && rd_ok && wr_ok) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rt_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rt_n    (rt_n),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  replay_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ok   (wr_ok),
    .wr_addr (wr_ptr),
    .wr_data (wr_data),
    .rd_ok   (rd_ok),
    .rd_addr (rd_ptr),
    .rd_data (rd_data)
  );

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!empty_n && rd_en && rt_n && !wr_en) |=> ($stable(rd_data) && !empty_n)); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!empty_n && !full_n)); // R3
  AST_RT_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rt_n |=> $stable(rd_data)); // R10
  AST_HALF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !full_n |-> !half_n); // R6
endmodule

// File: tb/replay_fifo_tb.sv
module replay_fifo_tb;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, rt_n;
  logic [8:0] wr_data;
  logic [8:0] rd_data;
  logic       empty_n, full_n, half_n;

  int checks = 0;
  int fails  = 0;

  logic [8:0] q[$];
  logic [8:0] hist[$];
  logic [8:0] exp_data;

  always #10 clk = ~clk;

  replay_fifo #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rt_n(rt_n), .rd_data(rd_data),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rt_n = 1; wr_data = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    q.delete(); hist.delete(); exp_data = '0;
  endtask

  // One clock: drive, let the edge pass, compare every output with the model.
  task automatic step(input string tag, input logic we, input logic [8:0] wd,
                      input logic re, input logic rt);
    logic full_m, empty_m;
    full_m  = (q.size() == D);
    empty_m = (q.size() == 0);
    wr_en = we; wr_data = wd; rd_en = re; rt_n = rt;
    if (!rt) begin
      if (we && !full_m) hist.push_back(wd);
      q = hist;
    end else begin
      if (re && !empty_m) exp_data = q.pop_front();
      if (we && !full_m) begin q.push_back(wd); hist.push_back(wd); end
    end
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; rt_n = 1;
    chk(tag, rd_data, exp_data);
    chk("R3 empty_n", {8'b0, empty_n}, {8'b0, q.size() != 0});
    chk("R3 full_n", {8'b0, full_n}, {8'b0, q.size() != D});
    chk("R6 half_n", {8'b0, half_n}, {8'b0, !(q.size() > D/2)});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_data", rd_data, 9'h000);
    chk("R1 empty_n", {8'b0, empty_n}, 9'h000);
    chk("R1 full_n", {8'b0, full_n}, 9'h001);
    chk("R1 half_n", {8'b0, half_n}, 9'h001);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 5; i++) step("R2 write", 1, 9'(9'h100 | (i * 7)), 0, 1);
    for (int i = 0; i < 5; i++) step("R2 read order", 0, '0, 1, 1);
  endtask

  task automatic t_full_half();
    do_reset();
    for (int i = 0; i < D; i++) step("R6 fill", 1, 9'(i + 3), 0, 1);
    step("R4 write while full", 1, 9'h1FF, 0, 1);
    step("R4 write while full again", 1, 9'h0AA, 0, 1);
    for (int i = 0; i < D; i++) step("R4 drain unchanged", 0, '0, 1, 1);
  endtask

  task automatic t_empty_read();
    do_reset();
    step("R5 read empty at reset", 0, '0, 1, 1);
    step("R5 one write", 1, 9'h055, 0, 1);
    step("R5 read it", 0, '0, 1, 1);
    step("R5 read while empty holds data", 0, '0, 1, 1);
    step("R5 read while empty again", 0, '0, 1, 1);
  endtask

  task automatic t_simul();
    do_reset();
    step("R8 write+read on empty", 1, 9'h011, 1, 1);
    for (int i = 0; i < 4; i++) step("R8 prefill", 1, 9'(9'h020 + i), 0, 1);
    for (int i = 0; i < 6; i++) step("R8 write+read mid", 1, 9'(9'h040 + i), 1, 1);
    while (q.size() < D) step("R8 fill", 1, 9'(9'h080 + q.size()), 0, 1);
    step("R8 write+read on full", 1, 9'h1EE, 1, 1);
    while (q.size() > 0) step("R8 drain", 0, '0, 1, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < D - 3; i++) step("R9 wrap write", 1, 9'(pass * 64 + i), 0, 1);
      for (int i = 0; i < D - 3; i++) step("R9 wrap read", 0, '0, 1, 1);
    end
  endtask

  task automatic t_retransmit();
    do_reset();
    for (int i = 0; i < 10; i++) step("R7 load", 1, 9'(9'h0C0 + i), 0, 1);
    for (int i = 0; i < 7; i++) step("R7 partial read", 0, '0, 1, 1);
    step("R10 retransmit with read and write", 1, 9'h13C, 1, 0);
    for (int i = 0; i < 11; i++) step("R7 replay from start", 0, '0, 1, 1);
    step("R7 second retransmit", 0, '0, 0, 0);
    step("R7 replay first word", 0, '0, 1, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_order();
        t_full_half();
        t_empty_read();
        t_simul();
        t_wrap();
        t_retransmit();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule